// File: doc/BRIEF.md
# Sequenced Seven-Bit Data Distributor

This block takes a stream of bytes arriving one per strobe on an 8-bit port and spreads them over four 8-bit outputs. Bit 7 of every byte sets its type. When bit 7 is 0, the byte is a data byte and carries a 7-bit payload. When bit 7 is 1, the byte is a control byte and carries commands.

The payloads of successive data bytes fill five 7-bit storage slots in a fixed order. A one-hot ring sequencer picks the next slot and returns to the first slot after the fifth. Slots one to four hold the low seven bits of outputs 0 to 3. The fifth slot is shared: its low bits supply the top bit of each output.

A control byte can send the sequencer back to the first slot. It can also switch the outputs on or off. While the outputs are off, they read as zero and the enable flag is low. The byte source therefore needs no address bits. It only has to keep its data bytes in step with the ring, using a restart command when it wants a known starting point.

Top module: `seven_bit_distributor`

## Requirements
- R1: After a synchronous reset, all slots are cleared, the sequencer points at the first slot, `out_en` is 0 and `out_bus` is 0.
- R2: In a cycle where `in_valid` is 0, the value on `in_byte` changes no state. No slot, sequencer position or enable state changes.
- R3: An accepted byte with bit 7 = 0 stores bits 6..0 in the slot the sequencer points at. The sequencer then advances, so that slots 1, 2, 3, 4 and 5 are filled in that order.
- R4: The data byte that writes slot 5 returns the sequencer to slot 1. The sixth data byte after a restart overwrites slot 1.
- R5: With the outputs enabled, output n (for n from 0 to 3) occupies `out_bus[8n+7:8n]`. Its bits 6..0 equal slot n+1, and its bit 7 equals bit n of slot 5. Bits 6..4 of slot 5 are stored but drive no output.
- R6: An accepted byte with bit 7 = 1 leaves every slot unchanged. If its bit 0 is 0, the sequencer position is also unchanged.
- R7: A control byte with bit 0 = 1 returns the sequencer to slot 1.
- R8: A control byte with bit 1 = 1 loads the enable state from its bit 2. A control byte with bit 1 = 0 leaves the enable state unchanged.
- R9: While the enable state is 0, `out_en` is 0 and `out_bus` is all zero. Data bytes are still stored during this time and appear once the outputs are enabled.
- R10: A control byte with bits 0 and 1 both set performs the restart and the enable load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte strobe; `in_byte` is taken only when high |
| in_byte | input | 8 | Incoming byte: bit 7 is the type, bits 6..0 are the payload or command |
| out_bus | output | 32 | Four 8-bit outputs; output n is at bits 8n+7..8n |
| out_en | output | 1 | Output enable state |

## Verification
The assertions check the following on every cycle:
- the sequencer always holds exactly one set bit;
- a data byte advances the sequencer, and a data byte in slot 5 wraps it to slot 1;
- a restart command returns it to slot 1;
- an idle cycle or a command byte leaves the slots untouched;
- an enable-load command sets the enable state from its value bit;
- a disabled block drives all-zero outputs.

Only the bench scenarios can show that each payload lands in the correct slot and that the shared fifth slot's bits reach the right output's top bit. The bench scenarios also cover data written while disabled appearing later, and combined restart-and-enable commands under long random byte mixes.

// File: rtl/seqdist_pkg.sv
package seqdist_pkg;

    // Byte framing
    localparam int BYTE_W   = 8;
    localparam int TYPE_BIT = BYTE_W - 1;
    localparam int PAY_W    = BYTE_W - 1;

    // Output fan-out: one slot per output plus one shared top-bit slot
    localparam int DEF_OUTS = 4;

    // Command bit positions inside a control byte
    localparam int CMD_RESTART_BIT = 0;
    localparam int CMD_ENLOAD_BIT  = 1;
    localparam int CMD_ENVAL_BIT   = 2;

    typedef enum logic {
        KIND_DATA = 1'b0,
        KIND_CTRL = 1'b1
    } byte_kind_e;

    typedef struct packed {
        logic restart;
        logic en_load;
        logic en_value;
    } ctrl_cmd_t;

    typedef struct packed {
        logic             data_wr;
        logic [PAY_W-1:0] payload;
        logic             cmd_valid;
        ctrl_cmd_t        cmd;
    } decoded_t;

    function automatic byte_kind_e kind_of(input logic [BYTE_W-1:0] b);
        return byte_kind_e'(b[TYPE_BIT]);
    endfunction

    function automatic ctrl_cmd_t cmd_of(input logic [BYTE_W-1:0] b);
        ctrl_cmd_t c;
        c.restart  = b[CMD_RESTART_BIT];
        c.en_load  = b[CMD_ENLOAD_BIT];
        c.en_value = b[CMD_ENVAL_BIT];
        return c;
    endfunction

endpackage

// File: rtl/byte_decoder.sv
module byte_decoder
    import seqdist_pkg::*;
(
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output decoded_t          dec
);

    byte_kind_e kind;

    always_comb begin
        kind          = kind_of(in_byte);
        dec.payload   = in_byte[PAY_W-1:0];
        dec.data_wr   = in_valid && (kind == KIND_DATA);
        dec.cmd_valid = in_valid && (kind == KIND_CTRL);
        if (dec.cmd_valid) begin
            dec.cmd = cmd_of(in_byte);
        end else begin
            dec.cmd = '0;
        end
    end

endmodule

// File: rtl/slot_ring.sv
module slot_ring #(
    parameter int SLOTS = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             restart,
    output logic [SLOTS-1:0] sel
);

    localparam logic [SLOTS-1:0] FIRST = {{(SLOTS-1){1'b0}}, 1'b1};

    logic [SLOTS-1:0] sel_q;
    logic [SLOTS-1:0] sel_d;

    always_comb begin
        sel_d = sel_q;
        if (restart) begin
            sel_d = FIRST;
        end else if (step) begin
            sel_d = {sel_q[SLOTS-2:0], sel_q[SLOTS-1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= FIRST;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign sel = sel_q;

    // R3: the ring pointer always selects exactly one slot
    assert_ring_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(sel_q) == 1);

    // R3: a data byte moves the pointer to the following slot
    assert_ring_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !restart && !sel_q[SLOTS-1]) |=> (sel_q == ($past(sel_q) << 1)));

    // R4: a data byte in the last slot wraps to the first
    assert_ring_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !restart && sel_q[SLOTS-1]) |=> sel_q[0]);

    // R7: restart returns to the first slot
    assert_ring_restart_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> (sel_q == FIRST));

    // R2 / R6: without a step or restart the pointer holds
    assert_ring_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!step && !restart) |=> $stable(sel_q));

endmodule

// File: rtl/slot_bank.sv
module slot_bank #(
    parameter int SLOTS = 5,
    parameter int W     = 7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr,
    input  logic [SLOTS-1:0]        sel,
    input  logic [W-1:0]            wdata,
    output logic [SLOTS-1:0][W-1:0] slots
);

    logic [SLOTS-1:0][W-1:0] store_q;

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    store_q[s] <= '0;
                end else if (wr && sel[s]) begin
                    store_q[s] <= wdata;
                end
            end
        end
    endgenerate

    assign slots = store_q;

    // R6 / R2: without a data write, no slot changes
    assert_bank_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(store_q));

endmodule

// File: rtl/out_merge.sv
module out_merge
    import seqdist_pkg::*;
#(
    parameter int NOUT = DEF_OUTS,
    parameter int W    = PAY_W
) (
    input  logic                   en,
    input  logic [NOUT:0][W-1:0]   slots,
    output logic [NOUT*BYTE_W-1:0] bus
);

    localparam int SPARE = NOUT;

    generate
        if (NOUT > W) begin : g_bad_cfg
            initial $error("out_merge: spare slot too narrow for output count");
        end
        for (genvar n = 0; n < NOUT; n++) begin : g_lane
            logic [BYTE_W-1:0] lane;
            always_comb begin
                lane = {slots[SPARE][n], slots[n]};
                if (!en) begin
                    lane = '0;
                end
            end
            assign bus[n*BYTE_W +: BYTE_W] = lane;
        end
    endgenerate

endmodule

// File: rtl/seven_bit_distributor.sv
module seven_bit_distributor
    import seqdist_pkg::*;
#(
    parameter int NUM_OUT = DEF_OUTS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [BYTE_W-1:0]         in_byte,
    output logic [NUM_OUT*BYTE_W-1:0] out_bus,
    output logic                      out_en
);

    localparam int NUM_SLOTS = NUM_OUT + 1;

    decoded_t                      dec;
    logic [NUM_SLOTS-1:0]          sel;
    logic [NUM_SLOTS-1:0][PAY_W-1:0] slots;
    logic                          en_q;

    byte_decoder u_dec (
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .dec      (dec)
    );

    slot_ring #(.SLOTS(NUM_SLOTS)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .step    (dec.data_wr),
        .restart (dec.cmd.restart),
        .sel     (sel)
    );

    slot_bank #(.SLOTS(NUM_SLOTS), .W(PAY_W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr    (dec.data_wr),
        .sel   (sel),
        .wdata (dec.payload),
        .slots (slots)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else if (dec.cmd.en_load) begin
            en_q <= dec.cmd.en_value;
        end
    end

    out_merge #(.NOUT(NUM_OUT), .W(PAY_W)) u_merge (
        .en    (en_q),
        .slots (slots),
        .bus   (out_bus)
    );

    assign out_en = en_q;

    // R8: an enable-load command takes the value bit
    assert_en_load_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_byte[TYPE_BIT] && in_byte[CMD_ENLOAD_BIT])
            |=> (out_en == $past(in_byte[CMD_ENVAL_BIT])));

    // R8 / R2: enable holds unless an enable-load command arrives
    assert_en_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_byte[TYPE_BIT] && in_byte[CMD_ENLOAD_BIT]) |=> $stable(out_en));

    // R9: disabled outputs read as zero
    assert_off_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (out_bus == '0));

endmodule

// File: tb/sim_seven_bit_distributor.sv
`timescale 1ns/1ps
module sim_seven_bit_distributor;

    localparam int NOUT = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  in_byte;
    logic [31:0] out_bus;
    logic        out_en;

    int n_chk  = 0;
    int n_fail = 0;

    logic [6:0] m_slot [5];
    int         m_ptr;
    logic       m_en;

    always #2.5 clk = ~clk;

    seven_bit_distributor u0 (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .out_bus  (out_bus),
        .out_en   (out_en)
    );

    function automatic logic [31:0] exp_bus();
        logic [31:0] r = '0;
        if (m_en) begin
            for (int n = 0; n < NOUT; n++) begin
                r[n*8 +: 8] = {m_slot[4][n], m_slot[n]};
            end
        end
        return r;
    endfunction

    function automatic void model_reset();
        for (int s = 0; s < 5; s++) m_slot[s] = '0;
        m_ptr = 0;
        m_en  = 1'b0;
    endfunction

    function automatic void model_byte(input logic [7:0] b);
        if (!b[7]) begin
            m_slot[m_ptr] = b[6:0];
            m_ptr = (m_ptr == 4) ? 0 : m_ptr + 1;
        end else begin
            if (b[0]) m_ptr = 0;
            if (b[1]) m_en = b[2];
        end
    endfunction

    task automatic check(input string tag);
        logic [31:0] eb;
        eb = exp_bus();
        n_chk++;
        if (out_bus !== eb || out_en !== m_en) begin
            n_fail++;
            $display("FAIL %s: out_bus=%h out_en=%b expected out_bus=%h out_en=%b",
                     tag, out_bus, out_en, eb, m_en);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'h00;
        model_byte(b);
    endtask

    task automatic idle(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = b;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240131));
        in_valid = 1'b0;
        in_byte  = 8'h00;
        rst      = 1'b1;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state");

        // R2: strobe low, bytes on the port are ignored
        idle(8'h86);
        idle(8'h7F);
        send(8'h86);           // enable on
        check("R2 idle bytes had no effect");
        send(8'h01);           // first slot, proves pointer did not move on idle
        check("R2 pointer unchanged by idle");

        // R9: disable, then fill all five slots while off
        send(8'h82);
        send(8'h81);           // restart
        check("R9 disabled reads zero");
        send(8'h11); send(8'h22); send(8'h33); send(8'h44);
        check("R9 still zero while filling");
        send(8'h7A);           // slot 5: bits 1 and 3 set plus unused high bits
        check("R9 outputs zero with full slots");

        // R8 / R3 / R5: enable shows stored data
        send(8'h86);
        check("R3 slot order visible after enable");
        check("R5 spare slot supplies top bits");

        // R4: sixth data byte overwrites slot 1
        send(8'h55);
        check("R4 wrap to first slot");
        send(8'h66);
        check("R4 continues at second slot");

        // R6: control with no commands leaves everything
        send(8'h80);
        send(8'hF8);
        check("R6 control byte keeps slots");
        send(8'h0F);           // goes to slot 3
        check("R6 pointer held by control");

        // R7: restart then data lands in slot 1
        send(8'h81);
        send(8'h3C);
        check("R7 restart to first slot");

        // R8: bit1 clear leaves enable; bit1 set with bit2 clear disables
        send(8'h84);
        check("R8 enable unchanged without load bit");
        send(8'h82);
        check("R8 load disables");

        // R10: restart and enable in one byte
        send(8'h00);           // slot 2
        send(8'h87);
        send(8'h7F);           // slot 1
        check("R10 combined restart and enable");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            if (($urandom % 5) == 0) begin
                idle(b);
                check("R2 random idle");
            end else begin
                send(b);
                check(b[7] ? "R6 random control" : "R3 random data");
            end
        end

        // Reset mid-stream returns to the R1 state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R1 reset after traffic");
        send(8'h86);
        check("R1 slots cleared by reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule